// File: doc/BRIEF.md
# Watchdog Timer with Prescaler and Selectable Clear Scheme

This block counts ticks of a watchdog clock. Software must clear it on time, or it raises an overflow pulse for the reset and wake sequencer. The tick source is fixed by a strap. It is either a free-running low-speed oscillator, or the system clock divided by 2^DIV_W (by 4 at the default). With the divided source, a prescaler stage counts the system clock edges, and the main counter advances once per prescaler wrap. With the oscillator source, the main counter advances on every oscillator edge. After 2^CNT_W ticks the counter wraps to zero and `ovf` pulses for one watchdog clock cycle.

Software clears the timer in one of two ways, chosen by a configuration strap. In single mode, one clear strobe is enough. In paired mode, two distinct strobes must both arrive, in any order, before the clear happens. Two "seen" latches remember which half of the pair has arrived. The latches are dropped on every clear, so repeating the same half never restarts the timer.

Entering the low-power halt state also clears the counter and the prescaler. While halted, the timer freezes if it runs from the divided system clock, because that clock stops in halt. It keeps counting if it runs from the oscillator. The clear strobes come from the system clock domain and are carried into the watchdog clock domain by toggle synchronizers. The halt level is carried by a two-stage synchronizer.

Top module: `watchdog_guard`

## Requirements
- R1: While `rst_n` is low, `ovf` is low. After release, the counter and the prescaler start from zero, so with no clear the first `ovf` appears exactly 2^CNT_W ticks after release (128 system clock edges for CNT_W=5, DIV_W=2, divided source).
- R2: With no clear, `ovf` repeats every 2^CNT_W ticks. One tick is 2^DIV_W system clock cycles when `src_sys`=1, and one oscillator cycle when `src_sys`=0.
- R3: `ovf` is high for exactly one watchdog clock cycle per wrap, and counting resumes from zero.
- R4: With `paired_mode`=0, a one-cycle pulse on `clr_one` zeroes both the counter and the prescaler. The zeroing happens on the fourth watchdog clock edge after the strobe is driven, counting the system clock edge that samples it as the first. With the divided source, the next `ovf` therefore comes 2^CNT_W·2^DIV_W + 4 system clock edges after the edge on which the strobe was driven.
- R5: With `paired_mode`=0, pulses on `clr_a` and `clr_b` have no effect on the overflow timing.
- R6: With `paired_mode`=1, the clear happens only once both `clr_a` and `clr_b` have arrived, in either order or in the same cycle. The clear lands with the R4 latency counted from the later of the two strobes. A pulse on `clr_one` has no effect in this mode.
- R7: With `paired_mode`=1, every clear drops both "seen" latches. Repeating only one half of the pair, before or after a completed pair, never clears the counter.
- R8: A rising edge of `halt`, after synchronization, zeroes the counter and the prescaler.
- R9: With `src_sys`=1 and `halt` high, the counter and the prescaler hold their value and no `ovf` occurs. Counting resumes from the held value about two watchdog clock cycles after `halt` falls.
- R10: With `src_sys`=0, the counter keeps advancing while `halt` is high, and `ovf` keeps recurring every 2^CNT_W oscillator cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; clear strobes are driven in this domain |
| osc_clk | input | 1 | Free-running low-speed oscillator clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| src_sys | input | 1 | Tick source strap: 1 = divided system clock, 0 = oscillator |
| paired_mode | input | 1 | Clear scheme strap: 0 = single strobe, 1 = both paired strobes |
| halt | input | 1 | Level, high while the device is in the halt state |
| clr_one | input | 1 | Single-scheme clear strobe, one system clock cycle wide |
| clr_a | input | 1 | First paired-scheme clear strobe, one system clock cycle wide |
| clr_b | input | 1 | Second paired-scheme clear strobe, one system clock cycle wide |
| ovf | output | 1 | Overflow pulse, one watchdog clock cycle wide |

## Verification
The assertions assume that `src_sys` and `paired_mode` change only while `rst_n` is low, since the clock mux and the clear scheme are treated as straps. They also assume that successive strobes on one line are several watchdog clock cycles apart, because the toggle synchronizers lose a second toggle that arrives before the first has crossed. The stimulus therefore changes the straps only inside a reset phase. It spaces the strobes of each line ten or more system cycles apart, and it holds `halt` for hundreds of cycles so that every edge of the level crosses cleanly.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

  // Index of each clear strobe inside the synchronized strobe vector.
  localparam int STB_ONE = 0;
  localparam int STB_A   = 1;
  localparam int STB_B   = 2;
  localparam int STB_N   = 3;

  // Number of watchdog clock cycles in one overflow period.
  function automatic int unsigned period_cycles(input int cnt_w, input int div_w,
                                                input bit src_sys);
    int unsigned ticks;
    ticks = 32'd1 << cnt_w;
    return src_sys ? (ticks << div_w) : ticks;
  endfunction

  // A pair is complete when each half has either been seen already or arrives now.
  function automatic logic pair_complete(input logic seen_a, input logic hit_a,
                                         input logic seen_b, input logic hit_b);
    return (seen_a | hit_a) & (seen_b | hit_b);
  endfunction

  // A counter tick is due every cycle for the oscillator source,
  // and once per prescaler wrap for the divided source.
  function automatic logic tick_due(input logic src_sys, input logic pre_full);
    return src_sys ? pre_full : 1'b1;
  endfunction

endpackage

// File: rtl/wdt_pulse_sync.sv
`timescale 1ns/1ps
module wdt_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic dst_clk,
  input  logic rst_n,
  input  logic strobe,
  output logic pulse
);
  localparam int DEPTH = STAGES + 1;

  logic             tgl_q;
  logic [DEPTH-1:0] sh_q;

  // Source side: every strobe flips the toggle.
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n)      tgl_q <= 1'b0;
    else if (strobe) tgl_q <= ~tgl_q;
  end

  // Destination side: synchronizer stages plus one stage for edge detection.
  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[DEPTH-2:0], tgl_q};
  end

  assign pulse = sh_q[DEPTH-2] ^ sh_q[DEPTH-1];
endmodule

// File: rtl/wdt_level_sync.sv
`timescale 1ns/1ps
module wdt_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/wdt_clear_sel.sv
`timescale 1ns/1ps
module wdt_clear_sel
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic paired,
  input  logic hit_one,
  input  logic hit_a,
  input  logic hit_b,
  input  logic ctr_clr,
  output logic instr_clr
);
  logic seen_a_q, seen_b_q;

  // Every clear of the counter drops both halves of the pair.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else if (ctr_clr) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else if (paired) begin
      seen_a_q <= seen_a_q | hit_a;
      seen_b_q <= seen_b_q | hit_b;
    end
  end

  assign instr_clr = paired ? pair_complete(seen_a_q, hit_a, seen_b_q, hit_b) : hit_one;

  // R7: after any clear, both halves must be collected again.
  p_seen_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_clr |=> (!seen_a_q && !seen_b_q));

  // R6: both halves are never held together; the pair completes at once.
  p_never_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(seen_a_q && seen_b_q));

  // R6: in paired mode the single strobe alone never clears.
  p_one_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (paired && !hit_a && !hit_b) |-> !instr_clr);

  // R5: in single mode the paired strobes never clear.
  p_pair_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!paired && !hit_one) |-> !instr_clr);
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_sys,
  input  logic             run,
  input  logic             clr,
  output logic             ovf,
  output logic [CNT_W-1:0] cnt_o
);
  logic [DIV_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             tick, adv, wrap;

  assign tick = tick_due(src_sys, pre_q == {DIV_W{1'b1}});
  assign adv  = run && tick;
  assign wrap = adv && (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr) begin
      pre_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= wrap;
      if (run && src_sys) pre_q <= pre_q + 1'b1;
      if (adv)            cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ovf   = ovf_q;
  assign cnt_o = cnt_q;

  // R4: a clear leaves both the prescaler and the counter at zero.
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && pre_q == '0));

  // R3: the overflow pulse is one cycle wide.
  p_ovf_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> !ovf_q);

  // R3: the overflow coincides with a counter at zero.
  p_ovf_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == '0));

  // R9: a halted divided-source timer holds its state.
  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> ($stable(cnt_q) && $stable(pre_q)));

  // R10: the oscillator source advances on every cycle.
  p_osc_advance_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !src_sys && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/watchdog_guard.sv
`timescale 1ns/1ps
module watchdog_guard
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic sys_clk,
  input  logic osc_clk,
  input  logic rst_n,
  input  logic src_sys,
  input  logic paired_mode,
  input  logic halt,
  input  logic clr_one,
  input  logic clr_a,
  input  logic clr_b,
  output logic ovf
);
  logic              wclk;
  logic [STB_N-1:0]  stb_in;
  logic [STB_N-1:0]  stb_hit;
  logic              halt_s, halt_q, halt_entry;
  logic              instr_clr, ctr_clr, run;
  logic [CNT_W-1:0]  cnt;

  // Static source strap: the mux only switches while reset is held.
  assign wclk   = src_sys ? sys_clk : osc_clk;

  assign stb_in[STB_ONE] = clr_one;
  assign stb_in[STB_A]   = clr_a;
  assign stb_in[STB_B]   = clr_b;

  for (genvar g = 0; g < STB_N; g++) begin : g_stb
    wdt_pulse_sync #(.STAGES(SYNC_STAGES)) u_ps (
      .src_clk (sys_clk),
      .dst_clk (wclk),
      .rst_n   (rst_n),
      .strobe  (stb_in[g]),
      .pulse   (stb_hit[g])
    );
  end

  wdt_level_sync #(.STAGES(SYNC_STAGES)) u_halt_sync (
    .clk   (wclk),
    .rst_n (rst_n),
    .d     (halt),
    .q     (halt_s)
  );

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_s;
  end

  assign halt_entry = halt_s & ~halt_q;

  wdt_clear_sel u_clr (
    .clk       (wclk),
    .rst_n     (rst_n),
    .paired    (paired_mode),
    .hit_one   (stb_hit[STB_ONE]),
    .hit_a     (stb_hit[STB_A]),
    .hit_b     (stb_hit[STB_B]),
    .ctr_clr   (ctr_clr),
    .instr_clr (instr_clr)
  );

  assign ctr_clr = instr_clr | halt_entry;
  assign run     = ~(halt_s & src_sys);

  wdt_counter #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_cnt (
    .clk     (wclk),
    .rst_n   (rst_n),
    .src_sys (src_sys),
    .run     (run),
    .clr     (ctr_clr),
    .ovf     (ovf),
    .cnt_o   (cnt)
  );

  // R8: halt entry leaves the counter at zero on the next cycle.
  p_halt_entry_clear_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    halt_entry |=> (cnt == '0 && !ovf));

  // R9: no overflow while a divided-source timer sits in halt.
  p_halt_quiet_r9: assert property (@(posedge wclk) disable iff (!rst_n)
    (halt_s && $past(halt_s) && src_sys) |-> !ovf);
endmodule

// File: tb/sim_watchdog_guard.sv
`timescale 1ns/1ps
module sim_watchdog_guard;
  localparam int CNT_W   = 5;
  localparam int DIV_W   = 2;
  localparam int PER_OSC = 1 << CNT_W;
  localparam int PER_SYS = (1 << CNT_W) * (1 << DIV_W);
  localparam int CLR_LAT = 4;

  logic sys_clk = 1'b0, osc_clk = 1'b0;
  logic rst_n = 1'b0, src_sys = 1'b1, paired_mode = 1'b0, halt = 1'b0;
  logic clr_one = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
  logic ovf;
  int   n_chk = 0, n_bad = 0;
  int   n;

  always #5  sys_clk = ~sys_clk;
  always #13 osc_clk = ~osc_clk;

  watchdog_guard #(.CNT_W(CNT_W), .DIV_W(DIV_W), .SYNC_STAGES(2)) u0 (
    .sys_clk(sys_clk), .osc_clk(osc_clk), .rst_n(rst_n), .src_sys(src_sys),
    .paired_mode(paired_mode), .halt(halt), .clr_one(clr_one), .clr_a(clr_a),
    .clr_b(clr_b), .ovf(ovf));

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: got %0d, expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic do_reset(input bit sys, input bit pair);
    rst_n = 1'b0; halt = 1'b0; clr_one = 1'b0; clr_a = 1'b0; clr_b = 1'b0;
    src_sys = sys; paired_mode = pair;
    repeat (6) @(negedge sys_clk);
    chk_eq("R1 ovf low in reset", int'(ovf), 0);
    rst_n = 1'b1;
  endtask

  // Drives strobes at given system negedges (0 = unused); returns edges to first ovf.
  task automatic run_sys(input int ta1, input int ta2, input int tb, input int t1,
                         output int res);
    res = -1;
    for (int i = 1; i <= 500; i++) begin
      @(negedge sys_clk);
      if (ovf) begin res = i; break; end
      clr_a   = (i == ta1) || (i == ta2);
      clr_b   = (i == tb);
      clr_one = (i == t1);
    end
    clr_a = 1'b0; clr_b = 1'b0; clr_one = 1'b0;
  endtask

  task automatic sys_width_and_gap(input string tag);
    int gap;
    @(negedge sys_clk);
    chk_eq({tag, " R3 ovf width"}, int'(ovf), 0);
    gap = -1;
    for (int i = 2; i <= 500; i++) begin
      @(negedge sys_clk);
      if (ovf) begin gap = i; break; end
    end
    chk_eq({tag, " R2 divided-source period"}, gap, PER_SYS);
  endtask

  task automatic osc_wait(output int res);
    res = -1;
    for (int i = 1; i <= 300; i++) begin
      @(negedge osc_clk);
      if (ovf) begin res = i; break; end
    end
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog R1..: run hung, got no end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // Sweep both clear schemes on both sources with no clears (R1, R2, R3).
    for (int pr = 0; pr < 2; pr++) begin
      do_reset(1'b1, pr[0]);
      run_sys(0, 0, 0, 0, n);
      chk_eq("R1 first ovf after reset", n, PER_SYS);
      sys_width_and_gap("sys");
      do_reset(1'b0, pr[0]);
      osc_wait(n);
      @(negedge osc_clk);
      chk_eq("R3 osc ovf width", int'(ovf), 0);
      osc_wait(n);
      chk_eq("R2 osc period", n + 1, PER_OSC);
    end

    // Single scheme (R4, R5).
    do_reset(1'b1, 1'b0);
    run_sys(0, 0, 0, 40, n);
    chk_eq("R4 clear at 40", n, 40 + PER_SYS + CLR_LAT);
    sys_width_and_gap("after clear");
    do_reset(1'b1, 1'b0);
    run_sys(0, 0, 0, 10, n);
    chk_eq("R4 clear at 10", n, 10 + PER_SYS + CLR_LAT);
    do_reset(1'b1, 1'b0);
    run_sys(40, 0, 60, 0, n);
    chk_eq("R5 paired strobes ignored", n, PER_SYS);
    do_reset(1'b1, 1'b0);
    begin
      int cnt_ovf = 0;
      for (int i = 1; i <= 800; i++) begin
        @(negedge sys_clk);
        if (ovf) cnt_ovf++;
        clr_one = (i % 100 == 0);
      end
      clr_one = 1'b0;
      chk_eq("R4 periodic clears keep ovf away", cnt_ovf, 0);
    end

    // Paired scheme (R6, R7).
    do_reset(1'b1, 1'b1);
    run_sys(20, 0, 50, 0, n);
    chk_eq("R6 a then b", n, 50 + PER_SYS + CLR_LAT);
    do_reset(1'b1, 1'b1);
    run_sys(70, 0, 20, 0, n);
    chk_eq("R6 b then a", n, 70 + PER_SYS + CLR_LAT);
    do_reset(1'b1, 1'b1);
    run_sys(30, 0, 30, 0, n);
    chk_eq("R6 same cycle", n, 30 + PER_SYS + CLR_LAT);
    do_reset(1'b1, 1'b1);
    run_sys(0, 0, 0, 30, n);
    chk_eq("R6 single strobe ignored", n, PER_SYS);
    do_reset(1'b1, 1'b1);
    run_sys(20, 60, 0, 0, n);
    chk_eq("R7 repeated a only", n, PER_SYS);
    do_reset(1'b1, 1'b1);
    run_sys(10, 60, 30, 0, n);
    chk_eq("R7 half after completed pair", n, 30 + PER_SYS + CLR_LAT);

    // Halt with the divided source (R8, R9).
    do_reset(1'b1, 1'b0);
    repeat (60) @(negedge sys_clk);
    halt = 1'b1;
    begin
      int cnt_ovf = 0;
      for (int i = 1; i <= 400; i++) begin
        @(negedge sys_clk);
        if (ovf) cnt_ovf++;
      end
      chk_eq("R9 no ovf while halted", cnt_ovf, 0);
    end
    halt = 1'b0;
    run_sys(0, 0, 0, 0, n);
    chk_rng("R8 halt entry cleared count", n, PER_SYS, PER_SYS + 4);
    chk_rng("R9 resume after release", n, PER_SYS + 1, PER_SYS + 3);

    // Halt with the oscillator source (R8, R10).
    do_reset(1'b0, 1'b0);
    repeat (5) @(negedge osc_clk);
    halt = 1'b1;
    osc_wait(n);
    chk_rng("R8 osc halt entry clear", n, PER_OSC + 1, PER_OSC + 5);
    osc_wait(n);
    chk_eq("R10 keeps counting in halt", n, PER_OSC);
    halt = 1'b0;
    @(negedge sys_clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule